// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the device-side logic of a byte-organised serial nonvolatile memory reached over a four-wire SPI link. A host selects it with an active-low chip select, clocks 8-bit instructions, 16-bit addresses and data on the serial input, and receives data or status on the serial output. The storage is an on-chip register array. Its depth is set by `ADDR_BITS`: 14 gives the full 16,384 bytes, and the default of 11 keeps elaboration small. All logic runs on a fast system clock. The chip select, serial clock and serial input are synchronised into that clock domain and their edges are detected there.

Six instructions are decoded: write enable (0x06), write disable (0x04), read status (0x05), write status (0x01), read (0x03) and write (0x02). A write collects up to one 64-byte page in a staging buffer. It is applied only after chip select returns high. The block then stays busy for an interval that stands in for the self-timed programming cycle: a 64-cycle copy plus `BUSY_CYCLES` clocks. A neighbouring protection block watches the status byte and the page number of the pending write. It answers with two permit inputs, which are sampled when chip select rises.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, `spi_so_oe` is 0 (serial output at high impedance) and `status_o` is 0x00.
- R2: The status byte is {bits 7:2 stored protection bits, bit 1 write-enable latch, bit 0 busy}. Opcode 0x06 sets the latch and 0x04 clears it. Opcode 0x05 shifts the status byte out MSB first and repeats it for as long as chip select stays low.
- R3: SI is sampled on rising SCK and SO changes only after falling SCK. Transfers with SCK idling low and transfers with SCK idling high give identical results.
- R4: Opcode 0x03 is followed by a 16-bit address, MSB first. Bit D7 of the addressed byte appears after the falling SCK edge that follows the last address bit. Reading continues with incrementing addresses and wraps from the last byte to byte 0. SI has no effect during the data phase.
- R5: Address bits at and above `ADDR_BITS` are ignored.
- R6: Opcode 0x02 is accepted only when the write-enable latch is set. Without it, no byte changes and no busy cycle starts.
- R7: During a write, only the six low address bits advance after each data byte, so the write wraps inside its 64-byte page. A 65th byte overwrites the first. Page bytes that are not received keep their old contents.
- R8: A write or status write is committed only if chip select rises on a byte boundary after at least one data byte. Otherwise nothing is written, no busy cycle starts and the latch keeps its value.
- R9: A committed page write keeps status bit 0 high for exactly 64 + `BUSY_CYCLES` clocks. During that time a status read returns 0xFF. The write-enable latch clears when the cycle ends.
- R10: While busy, every opcode except 0x05 is ignored and SO stays at high impedance.
- R11: Opcode 0x01 with the latch set loads bits 7:2 from the first data byte, ignores its bits 1:0 and starts a busy cycle of `BUSY_CYCLES` clocks. Without the latch it has no effect.
- R12: `wr_page_o` gives the page number (address bits above bit 5) of the current write. If `array_wr_ok` is low when chip select rises, the page write is dropped. If `stat_wr_ok` is low, the status write is dropped. In both cases no busy cycle starts.
- R13: An unknown opcode is ignored and SO stays at high impedance for the rest of the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| status_o | output | 8 | Live status byte for the protection block |
| wr_page_o | output | ADDR_BITS-6 | Page number of the current write |
| array_wr_ok | input | 1 | Protection permit for the page write |
| stat_wr_ok | input | 1 | Protection permit for the status write |

## Verification
Reads are run with both SCK idle levels and with SI held at all zeros and at all ones. The first shows that the edge choice does not depend on polarity; the second shows that SI is ignored once data is flowing. Writes are tried with a short burst near the end of a page, a 65-byte overrun, a single byte at the last address and a page left partly unwritten. These separate page wrap, overwrite, the byte mask and the read wrap across the whole array. Transfers cut short after three bits or after the address, writes without the latch, writes refused by the protection inputs and commands sent while busy each have to leave memory and status untouched. The busy pulse is counted cycle by cycle so that its length is checked exactly.

// File: rtl/spi_ee_pkg.sv
// Shared constants and types for the SPI EEPROM slave.
// Assumes byte-wide storage and 64-byte pages.
package spi_ee_pkg;
    localparam int PAGE_BITS = 6;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRIT = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADDR, PH_RDAT, PH_RSTAT, PH_WDAT, PH_SDAT, PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {
        WC_IDLE, WC_COPY, WC_WAIT
    } wcyc_t;
endpackage

// File: rtl/spi_ee_sync.sv
// Synchronises CS, SCK and SI into the system clock domain and flags their
// edges. Assumes the system clock is several times faster than SCK.
module spi_ee_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sck_in,
    input  logic si_in,
    output logic cs_act,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic [SYNC_STAGES-1:0][2:0] chain;
    logic                        cs_prev;
    logic                        sck_prev;
    logic                        cs_s;
    logic                        sck_s;

    // Shift the raw pins through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= 3'b100;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            chain[0] <= {cs_n_in, sck_in, si_in};
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    // Derive levels and single-cycle edge strobes.
    always_comb begin
        cs_s     = chain[SYNC_STAGES-1][2];
        sck_s    = chain[SYNC_STAGES-1][1];
        si_s     = chain[SYNC_STAGES-1][0];
        cs_act   = !cs_s;
        cs_fall  = cs_prev && !cs_s;
        cs_rise  = !cs_prev && cs_s;
        sck_rise = !sck_prev && sck_s;
        sck_fall = sck_prev && !sck_s;
    end
endmodule

// File: rtl/spi_ee_ctrl.sv
// Serial protocol engine: assembles bytes, decodes opcodes, tracks address,
// streams read data and status, and requests commits when CS rises.
// Assumes synchronised edge strobes, and that SCK and CS edges never coincide.
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BITS = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_act,
    input  logic                          cs_fall,
    input  logic                          cs_rise,
    input  logic                          sck_rise,
    input  logic                          sck_fall,
    input  logic                          si_s,
    input  logic                          busy,
    input  logic                          wel,
    input  logic [7:0]                    stat,
    input  logic [7:0]                    rd_data,
    output logic [ADDR_BITS-1:0]          rd_addr,
    output logic [ADDR_BITS-PAGE_BITS-1:0] page_base,
    output logic                          wel_set,
    output logic                          wel_clr,
    output logic                          pb_start,
    output logic                          pb_we,
    output logic [PAGE_BITS-1:0]          pb_idx,
    output logic [7:0]                    pb_data,
    output logic                          page_go,
    output logic                          sr_go,
    output logic [7:0]                    sr_data,
    output logic                          so,
    output logic                          so_oe
);
    phase_t               phase;
    logic [2:0]           bit_cnt;
    logic [6:0]           rx;
    logic [7:0]           rx_byte;
    logic                 addr_cnt;
    logic [7:0]           addr_hi;
    logic [ADDR_BITS-1:0] cur_addr;
    logic                 is_write;
    logic                 got_data;
    logic [2:0]           obit;
    logic [7:0]           tx_hold;
    logic [7:0]           tx_src;

    // Byte being completed this edge and source of the outgoing byte.
    always_comb begin
        rx_byte   = {rx, si_s};
        tx_src    = (phase == PH_RDAT) ? rd_data : (busy ? 8'hFF : stat);
        rd_addr   = cur_addr;
        page_base = cur_addr[ADDR_BITS-1:PAGE_BITS];
    end

    // Protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            rx       <= '0;
            addr_cnt <= 1'b0;
            addr_hi  <= '0;
            cur_addr <= '0;
            is_write <= 1'b0;
            got_data <= 1'b0;
            obit     <= '0;
            tx_hold  <= '0;
            so       <= 1'b0;
            so_oe    <= 1'b0;
            wel_set  <= 1'b0;
            wel_clr  <= 1'b0;
            pb_start <= 1'b0;
            pb_we    <= 1'b0;
            pb_idx   <= '0;
            pb_data  <= '0;
            page_go  <= 1'b0;
            sr_go    <= 1'b0;
            sr_data  <= '0;
        end else begin
            wel_set  <= 1'b0;
            wel_clr  <= 1'b0;
            pb_start <= 1'b0;
            pb_we    <= 1'b0;
            page_go  <= 1'b0;
            sr_go    <= 1'b0;
            if (cs_fall) begin
                phase    <= PH_OPC;
                bit_cnt  <= '0;
                got_data <= 1'b0;
                obit     <= '0;
                so_oe    <= 1'b0;
            end else if (!cs_act) begin
                if (cs_rise && bit_cnt == 3'd0 && got_data) begin
                    if (phase == PH_WDAT) page_go <= 1'b1;
                    if (phase == PH_SDAT) sr_go   <= 1'b1;
                end
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                so_oe   <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (sck_rise) begin
                    rx      <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        case (phase)
                            PH_OPC: begin
                                phase <= PH_SKIP;
                                case (rx_byte)
                                    OP_WREN: wel_set <= !busy;
                                    OP_WRDI: wel_clr <= !busy;
                                    OP_RDSR: begin
                                        phase <= PH_RSTAT;
                                        obit  <= '0;
                                    end
                                    OP_WRSR: if (!busy && wel) phase <= PH_SDAT;
                                    OP_READ: if (!busy) begin
                                        phase    <= PH_ADDR;
                                        is_write <= 1'b0;
                                        addr_cnt <= 1'b0;
                                    end
                                    OP_WRIT: if (!busy && wel) begin
                                        phase    <= PH_ADDR;
                                        is_write <= 1'b1;
                                        addr_cnt <= 1'b0;
                                        pb_start <= 1'b1;
                                    end
                                    default: phase <= PH_SKIP;
                                endcase
                            end
                            PH_ADDR: begin
                                if (!addr_cnt) begin
                                    addr_hi  <= rx_byte;
                                    addr_cnt <= 1'b1;
                                end else begin
                                    cur_addr <= ADDR_BITS'({addr_hi, rx_byte});
                                    obit     <= '0;
                                    phase    <= is_write ? PH_WDAT : PH_RDAT;
                                end
                            end
                            PH_WDAT: begin
                                pb_we    <= 1'b1;
                                pb_idx   <= cur_addr[PAGE_BITS-1:0];
                                pb_data  <= rx_byte;
                                cur_addr[PAGE_BITS-1:0] <= cur_addr[PAGE_BITS-1:0] + 1'b1;
                                got_data <= 1'b1;
                            end
                            PH_SDAT: begin
                                if (!got_data) sr_data <= rx_byte;
                                got_data <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end else if (sck_fall && (phase == PH_RDAT || phase == PH_RSTAT)) begin
                    so_oe <= 1'b1;
                    if (obit == 3'd0) begin
                        so      <= tx_src[7];
                        tx_hold <= tx_src;
                    end else begin
                        so <= tx_hold[3'd7 - obit];
                    end
                    obit <= obit + 3'd1;
                    if (phase == PH_RDAT && obit == 3'd7) cur_addr <= cur_addr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_ee_wcycle.sv
// Write-cycle engine: holds the page staging buffer with its byte mask, the
// status bits and the write-enable latch, and runs the copy and busy interval.
// Assumes the commit requests are single-cycle pulses from the protocol engine.
module spi_ee_wcycle
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BITS   = 11,
    parameter int BUSY_CYCLES = 625000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wel_set,
    input  logic                           wel_clr,
    input  logic                           pb_start,
    input  logic                           pb_we,
    input  logic [PAGE_BITS-1:0]           pb_idx,
    input  logic [7:0]                     pb_data,
    input  logic                           page_go,
    input  logic [ADDR_BITS-PAGE_BITS-1:0] page_base,
    input  logic                           array_ok,
    input  logic                           sr_go,
    input  logic [7:0]                     sr_data,
    input  logic                           stat_ok,
    output logic                           busy,
    output logic                           wel,
    output logic [7:0]                     stat,
    output logic                           mem_we,
    output logic [ADDR_BITS-1:0]           mem_addr,
    output logic [7:0]                     mem_wdata
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    wcyc_t                          state;
    logic [7:0]                     pbuf [PAGE_SIZE];
    logic [PAGE_SIZE-1:0]           pmask;
    logic [PAGE_BITS-1:0]           idx;
    logic [CNT_W-1:0]               cnt;
    logic [ADDR_BITS-PAGE_BITS-1:0] base_q;
    logic [5:0]                     bp;

    // Staging buffer data, no reset needed.
    always_ff @(posedge clk) begin
        if (pb_we) pbuf[pb_idx] <= pb_data;
    end

    // Byte mask, latch, status bits and the cycle sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WC_IDLE;
            pmask  <= '0;
            idx    <= '0;
            cnt    <= '0;
            base_q <= '0;
            bp     <= '0;
            wel    <= 1'b0;
        end else begin
            if (pb_start)   pmask <= '0;
            else if (pb_we) pmask[pb_idx] <= 1'b1;
            if (wel_set)      wel <= 1'b1;
            else if (wel_clr) wel <= 1'b0;
            case (state)
                WC_IDLE: begin
                    if (page_go && array_ok) begin
                        state  <= WC_COPY;
                        idx    <= '0;
                        base_q <= page_base;
                    end else if (sr_go && stat_ok) begin
                        bp    <= sr_data[7:2];
                        cnt   <= '0;
                        state <= WC_WAIT;
                    end
                end
                WC_COPY: begin
                    idx <= idx + 1'b1;
                    if (idx == PAGE_BITS'(PAGE_SIZE - 1)) begin
                        cnt   <= '0;
                        state <= WC_WAIT;
                    end
                end
                WC_WAIT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
                        state <= WC_IDLE;
                        wel   <= 1'b0;
                    end
                end
                default: state <= WC_IDLE;
            endcase
        end
    end

    // Array write port and status byte.
    always_comb begin
        busy      = (state != WC_IDLE);
        mem_we    = (state == WC_COPY) && pmask[idx];
        mem_addr  = {base_q, idx};
        mem_wdata = pbuf[idx];
        stat      = {bp, wel, busy};
    end
endmodule

// File: rtl/spi_ee_array.sv
// Byte storage with a synchronous write port and an asynchronous read port.
// Assumes contents are undefined until written.
module spi_ee_array #(
    parameter int ADDR_BITS = 11
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] waddr,
    input  logic [7:0]           wdata,
    input  logic [ADDR_BITS-1:0] raddr,
    output logic [7:0]           rdata
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [7:0] mem [DEPTH];

    // Store one byte per clock during the copy phase.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the byte selected by the read pointer.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_slave.sv
// Top level of the SPI EEPROM slave: joins the synchroniser, the protocol
// engine, the write-cycle engine and the storage array.
// Assumes modes 0 and 3 with SCK at most a quarter of the clk rate.
module spi_eeprom_slave
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BITS   = 11,
    parameter int BUSY_CYCLES = 625000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           spi_cs_n,
    input  logic                           spi_sck,
    input  logic                           spi_si,
    output logic                           spi_so,
    output logic                           spi_so_oe,
    output logic [7:0]                     status_o,
    output logic [ADDR_BITS-PAGE_BITS-1:0] wr_page_o,
    input  logic                           array_wr_ok,
    input  logic                           stat_wr_ok
);
    logic                           cs_act, cs_fall, cs_rise, sck_rise, sck_fall, si_s;
    logic                           busy, wel;
    logic [7:0]                     stat, rd_data, pb_data, sr_data, mem_wdata;
    logic [ADDR_BITS-1:0]           rd_addr, mem_addr;
    logic [ADDR_BITS-PAGE_BITS-1:0] page_base;
    logic                           wel_set, wel_clr, pb_start, pb_we, page_go, sr_go, mem_we;
    logic [PAGE_BITS-1:0]           pb_idx;

    spi_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_in(spi_cs_n), .sck_in(spi_sck), .si_in(spi_si),
        .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
    );

    spi_ee_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
        .busy(busy), .wel(wel), .stat(stat), .rd_data(rd_data),
        .rd_addr(rd_addr), .page_base(page_base),
        .wel_set(wel_set), .wel_clr(wel_clr), .pb_start(pb_start), .pb_we(pb_we),
        .pb_idx(pb_idx), .pb_data(pb_data), .page_go(page_go),
        .sr_go(sr_go), .sr_data(sr_data), .so(spi_so), .so_oe(spi_so_oe)
    );

    spi_ee_wcycle #(.ADDR_BITS(ADDR_BITS), .BUSY_CYCLES(BUSY_CYCLES)) u_wcyc (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .pb_start(pb_start), .pb_we(pb_we), .pb_idx(pb_idx), .pb_data(pb_data),
        .page_go(page_go), .page_base(page_base), .array_ok(array_wr_ok),
        .sr_go(sr_go), .sr_data(sr_data), .stat_ok(stat_wr_ok),
        .busy(busy), .wel(wel), .stat(stat),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    spi_ee_array #(.ADDR_BITS(ADDR_BITS)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    // Status and page number go straight out to the protection block.
    always_comb begin
        status_o  = stat;
        wr_page_o = page_base;
    end
endmodule

// File: rtl/spi_eeprom_checker.sv
// Temporal checks on the SPI EEPROM slave, attached to every instance by bind.
module spi_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic cs_rise,
    input logic sck_fall,
    input logic so,
    input logic so_oe,
    input logic busy,
    input logic wel,
    input logic mem_we
);
    // R13 and R1: output released once the device is deselected.
    a_r13_so_released: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_oe);

    // R3: a driven SO only changes one cycle after a falling SCK strobe.
    a_r3_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$stable(so)) |-> $past(sck_fall));

    // R8: a busy cycle starts two cycles after chip select rises.
    a_r8_busy_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise, 2));

    // R6: a busy cycle only begins with the latch set.
    a_r6_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);

    // R9: latch is clear when the busy cycle ends.
    a_r9_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R9: storage is only written inside a busy cycle.
    a_r9_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind spi_eeprom_slave spi_eeprom_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
    .sck_fall(sck_fall), .so(spi_so), .so_oe(spi_so_oe),
    .busy(busy), .wel(wel), .mem_we(mem_we)
);

// File: tb/spi_eeprom_slave_test.sv
// Directed bench for the SPI EEPROM slave.
module spi_eeprom_slave_test;
    localparam int AB   = 11;
    localparam int BUSY = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        so, so_oe;
    logic [7:0]  status;
    logic [AB-7:0] wpage;
    logic        array_ok = 1'b1;
    logic        stat_ok = 1'b1;
    logic        cpol = 1'b0;
    logic        done = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] wbuf [128];
    logic [7:0] rbuf [8];
    logic       rd_oe;

    always #4 clk = ~clk;

    spi_eeprom_slave #(.ADDR_BITS(AB), .BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .status_o(status), .wr_page_o(wpage),
        .array_wr_ok(array_ok), .stat_wr_ok(stat_ok)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx, output logic oe);
        rx = '0;
        oe = 1'b0;
        for (int i = 7; i > 7 - nb; i--) begin
            if (cpol) sck = 1'b0;
            si = tx[i];
            tick(8);
            rx[i] = so;
            if (so_oe) oe = 1'b1;
            sck = 1'b1;
            tick(8);
            if (!cpol) sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe);
        xbits(tx, 8, rx, oe);
    endtask

    task automatic cs_begin();
        sck = cpol;
        tick(4);
        cs_n = 1'b0;
        tick(8);
    endtask

    task automatic cs_end();
        tick(8);
        cs_n = 1'b1;
        tick(16);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] r; logic o;
        cs_begin(); xbyte(op, r, o); cs_end();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic o; logic [7:0] r;
        cs_begin(); xbyte(8'h05, r, o); xbyte(8'h00, v, o); cs_end();
    endtask

    task automatic wait_ready();
        logic [7:0] v;
        for (int k = 0; k < 30; k++) begin
            rdsr(v);
            if (v != 8'hFF) break;
        end
    endtask

    task automatic wr_data(input logic [15:0] a, input int n);
        logic [7:0] r; logic o;
        cs_begin();
        xbyte(8'h02, r, o); xbyte(a[15:8], r, o); xbyte(a[7:0], r, o);
        for (int i = 0; i < n; i++) xbyte(wbuf[i], r, o);
        cs_end();
    endtask

    task automatic rd_data(input logic [15:0] a, input int n, input logic [7:0] fill);
        logic [7:0] r; logic o;
        cs_begin();
        xbyte(8'h03, r, o); xbyte(a[15:8], r, o); xbyte(a[7:0], r, o);
        rd_oe = 1'b0;
        for (int i = 0; i < n; i++) begin
            xbyte(fill, rbuf[i], o);
            if (o) rd_oe = 1'b1;
        end
        cs_end();
    endtask

    task automatic wrsr(input logic [7:0] d);
        logic [7:0] r; logic o;
        cs_begin(); xbyte(8'h01, r, o); xbyte(d, r, o); cs_end();
    endtask

    task automatic t_reset();
        chk("R1", "status after reset", int'(status), 8'h00);
        chk("R1", "so_oe after reset", int'(so_oe), 0);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        rdsr(v); chk("R2", "status idle", int'(v), 8'h00);
        cmd(8'h06); rdsr(v); chk("R2", "status after 0x06", int'(v), 8'h02);
        cpol = 1'b1; rdsr(v); chk("R3", "status read with SCK idle high", int'(v), 8'h02);
        cpol = 1'b0;
        cmd(8'h04); rdsr(v); chk("R2", "status after 0x04", int'(v), 8'h00);
    endtask

    task automatic t_page_write();
        logic [7:0] v;
        cmd(8'h06);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
        wr_data(16'h0040, 4);
        chk("R9", "status_o during busy", int'(status), 8'h03);
        rdsr(v); chk("R9", "status read during busy", int'(v), 8'hFF);
        wait_ready();
        rdsr(v); chk("R9", "latch clear after cycle", int'(v), 8'h00);
        rd_data(16'h0040, 4, 8'h00);
        for (int i = 0; i < 4; i++) chk("R4", "read stream", int'(rbuf[i]), 8'hA0 + i);
    endtask

    task automatic t_read_modes();
        cpol = 1'b1;
        rd_data(16'h0040, 4, 8'h00);
        for (int i = 0; i < 4; i++) chk("R3", "read with SCK idle high", int'(rbuf[i]), 8'hA0 + i);
        cpol = 1'b0;
        rd_data(16'h0041, 2, 8'hFF);
        chk("R4", "SI ones ignored byte0", int'(rbuf[0]), 8'hA1);
        chk("R4", "SI ones ignored byte1", int'(rbuf[1]), 8'hA2);
        rd_data(16'hF840, 1, 8'h00);
        chk("R5", "upper address bits ignored", int'(rbuf[0]), 8'hA0);
    endtask

    task automatic t_no_latch();
        wbuf[0] = 8'hEE;
        wr_data(16'h0040, 1);
        chk("R6", "no busy without latch", int'(status), 8'h00);
        rd_data(16'h0040, 1, 8'h00);
        chk("R6", "byte unchanged without latch", int'(rbuf[0]), 8'hA0);
    endtask

    task automatic t_wrap();
        cpol = 1'b1;
        cmd(8'h06);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hB0 + 8'(i);
        wr_data(16'h007E, 4);
        wait_ready();
        cpol = 1'b0;
        rd_data(16'h007E, 2, 8'h00);
        chk("R7", "page byte 0x7E", int'(rbuf[0]), 8'hB0);
        chk("R7", "page byte 0x7F", int'(rbuf[1]), 8'hB1);
        rd_data(16'h0040, 3, 8'h00);
        chk("R7", "wrapped to page start", int'(rbuf[0]), 8'hB2);
        chk("R7", "wrapped second byte", int'(rbuf[1]), 8'hB3);
        chk("R7", "unwritten byte kept", int'(rbuf[2]), 8'hA2);
        cmd(8'h06);
        for (int i = 0; i < 65; i++) wbuf[i] = 8'(i + 1);
        wr_data(16'h0100, 65);
        wait_ready();
        rd_data(16'h0100, 2, 8'h00);
        chk("R7", "65th byte overwrites first", int'(rbuf[0]), 65);
        chk("R7", "second byte of full page", int'(rbuf[1]), 2);
    endtask

    task automatic t_read_wrap();
        cmd(8'h06); wbuf[0] = 8'h77; wr_data(16'h07FF, 1); wait_ready();
        cmd(8'h06); wbuf[0] = 8'h11; wr_data(16'h0000, 1); wait_ready();
        rd_data(16'h07FF, 2, 8'h00);
        chk("R4", "last byte", int'(rbuf[0]), 8'h77);
        chk("R4", "wrap to byte 0", int'(rbuf[1]), 8'h11);
    endtask

    task automatic t_boundary();
        logic [7:0] r; logic o;
        cmd(8'h06);
        cs_begin();
        xbyte(8'h02, r, o); xbyte(8'h01, r, o); xbyte(8'h00, r, o);
        xbyte(8'hC3, r, o); xbits(8'hFF, 3, r, o);
        cs_end();
        chk("R8", "no busy after partial byte", int'(status), 8'h02);
        rd_data(16'h0100, 1, 8'h00);
        chk("R8", "byte unchanged after partial", int'(rbuf[0]), 65);
        cs_begin();
        xbyte(8'h02, r, o); xbyte(8'h01, r, o); xbyte(8'h00, r, o);
        cs_end();
        chk("R8", "no busy without data byte", int'(status), 8'h02);
        cmd(8'h04);
    endtask

    task automatic t_busy();
        int n;
        logic [7:0] r; logic o;
        cmd(8'h06);
        cs_begin();
        xbyte(8'h02, r, o); xbyte(8'h01, r, o); xbyte(8'h40, r, o); xbyte(8'h5C, r, o);
        tick(8);
        cs_n = 1'b1;
        n = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (status[0]) n++;
            else if (n > 0) break;
        end
        chk("R9", "busy length in clocks", n, 64 + BUSY);
        cmd(8'h06);
        cs_begin();
        xbyte(8'h02, r, o); xbyte(8'h01, r, o); xbyte(8'h40, r, o); xbyte(8'h66, r, o);
        cs_end();
        rd_data(16'h0140, 1, 8'h00);
        chk("R10", "read ignored while busy, SO enabled", int'(rd_oe), 0);
        wait_ready();
        rd_data(16'h0140, 1, 8'h00);
        chk("R10", "write landed", int'(rbuf[0]), 8'h66);
    endtask

    task automatic t_protect();
        cmd(8'h06); wbuf[0] = 8'h44; wr_data(16'h0180, 1); wait_ready();
        array_ok = 1'b0;
        cmd(8'h06); wbuf[0] = 8'h99; wr_data(16'h0180, 1);
        chk("R12", "page number output", int'(wpage), 6);
        chk("R12", "no busy when array refused", int'(status), 8'h02);
        array_ok = 1'b1;
        rd_data(16'h0180, 1, 8'h00);
        chk("R12", "refused write left byte", int'(rbuf[0]), 8'h44);
        stat_ok = 1'b0;
        wrsr(8'hFC);
        chk("R12", "no busy when status refused", int'(status), 8'h02);
        stat_ok = 1'b1;
        cmd(8'h04);
    endtask

    task automatic t_wrsr();
        logic [7:0] v;
        cmd(8'h06);
        wrsr(8'h8F);
        chk("R11", "status_o during status write", int'(status), 8'h8F);
        wait_ready();
        rdsr(v); chk("R11", "stored protection bits", int'(v), 8'h8C);
        wrsr(8'h00);
        rdsr(v); chk("R11", "status write without latch", int'(v), 8'h8C);
    endtask

    task automatic t_unknown();
        logic [7:0] r; logic o, o2;
        cs_begin(); xbyte(8'hAB, r, o); xbyte(8'h00, r, o2); cs_end();
        chk("R13", "SO enabled for unknown opcode", int'(o | o2), 0);
        rdsr(r); chk("R13", "status unaffected", int'(r), 8'h8C);
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_latch();
        t_page_write();
        t_read_modes();
        t_no_latch();
        t_wrap();
        t_read_wrap();
        t_boundary();
        t_busy();
        t_protect();
        t_wrsr();
        t_unknown();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule